// File: doc/BRIEF.md
# Half-Band 2x Interpolation Filter

This block doubles the sample rate of a stream of 14-bit signed samples. It runs on the output-rate clock. A new input sample may be offered at most every second cycle, and each accepted sample produces two output samples on the two cycles that follow. The filter is a 43-tap linear-phase half-band FIR split into two polyphase branches.

- The first branch (phase A) is a 22-tap symmetric multiply-accumulate. Symmetric pairs are added before they are multiplied, so it needs 11 multipliers.
- Every other tap of a half-band filter is zero apart from the centre tap. The second branch (phase B) therefore reduces to a delayed copy of the input.

Results are scaled by 2^-14 with round-half-up and then clipped to the 14-bit range. A run-time mode input turns the low-pass response into a high-pass one. It does this by negating every phase-B output, which multiplies the 2x-rate stream by (-1)^n. The upper image is kept and the baseband is suppressed.

Top module: `hb_interp2x`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, `out_valid` is 0. After any reset, outputs stay invalid until the delay line has been refilled as stated in R8.
- R2: An input is accepted when `in_valid` is high on a clock edge. After acceptance, `out_valid` is high for exactly two cycles:
  - The cycle after acceptance carries phase A.
  - The next cycle carries phase B.
  - `out_valid` then drops, unless another sample was accepted on the edge where phase B was produced.
- R3: Phase A equals floor((S + 8192) / 16384), clipped, where S = sum over i=0..21 of c[i]·x[n-i], and x[n] is the newest accepted sample. The coefficients c[0..10] are 10, -31, 69, -138, 248, -419, 678, -1083, 1776, -3282, 10364, and c[21-i] = c[i].
- R4: In low-pass mode, phase B equals x[n-10] exactly.
- R5: The DC gain is unity. A constant input v gives v on both phases once the line is full.
- R6: Every output is clipped to [-8192, 8191] and never wraps.
- R7: While `hp_mode` is 1, phase B is negated with saturation, so -(-8192) gives 8191. Phase A is unchanged. The mode is the value `hp_mode` holds in the cycle before the output appears.
- R8: `out_valid` stays 0 for the outputs of the first 21 samples accepted after reset. The 22nd and later samples give valid outputs.
- R9: `in_valid` on the cycle right after an accepted sample is ignored and produces no outputs. Samples offered every second cycle are all accepted.
- R10: For an impulse preceded by zeros, the peak output (the input value itself) appears 21 output samples after the first output that the impulse affects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | SAMPLE_W | Input sample, two's complement |
| hp_mode | input | 1 | 1 selects the high-pass response |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | SAMPLE_W | Output sample, two's complement |

## Verification
The assertions check, on every cycle, the following:
- A phase-A output is always followed by a phase-B output.
- Phase B is the centre delay-tap value, copied in low-pass mode and negated with saturation in high-pass mode.
- No valid output appears before the line has filled.
- A strobe during the busy cycle leaves the delay line untouched.

Only the bench's scenarios can show the following, because the bench computes the full 22-tap sum independently:
- the exact phase-A arithmetic, including rounding and clipping;
- unity DC gain;
- the impulse peak position.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    localparam int NUM_TAPS   = 43;
    localparam int PHASE_TAPS = (NUM_TAPS + 1) / 2;
    localparam int CENTER_IDX = (NUM_TAPS - 3) / 4;
    localparam int COEF_SHIFT = 14;

    // Outer-to-inner coefficients of the non-trivial polyphase branch.
    function automatic int phase_coef(input int k);
        case (k)
            0:       return 10;
            1:       return -31;
            2:       return 69;
            3:       return -138;
            4:       return 248;
            5:       return -419;
            6:       return 678;
            7:       return -1083;
            8:       return 1776;
            9:       return -3282;
            10:      return 10364;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/hbi_tap_line.sv
module hbi_tap_line #(
    parameter int W     = 14,
    parameter int DEPTH = 22
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      shift_en,
    input  logic [W-1:0]              din,
    output logic [DEPTH-1:0][W-1:0]   taps
);
    logic [DEPTH-1:0][W-1:0] taps_d, taps_q;

    always_comb begin
        taps_d = taps_q;
        if (shift_en) begin
            taps_d[0] = din;
            for (int i = 1; i < DEPTH; i++) begin
                taps_d[i] = taps_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) taps_q <= '0;
        else     taps_q <= taps_d;
    end

    assign taps = taps_q;
endmodule

// File: rtl/hbi_phase_mac.sv
module hbi_phase_mac
    import hbi_pkg::*;
#(
    parameter int W     = 14,
    parameter int DEPTH = PHASE_TAPS,
    parameter int ACC_W = 32,
    parameter int SHIFT = COEF_SHIFT
) (
    input  logic [DEPTH-1:0][W-1:0] taps,
    output logic [W-1:0]            result
);
    localparam int PAIRS = DEPTH / 2;
    localparam int MAXV  = (1 << (W - 1)) - 1;
    localparam int MINV  = -(1 << (W - 1));

    logic signed [ACC_W-1:0] pair_sum [PAIRS];
    logic signed [ACC_W-1:0] prod     [PAIRS];
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] rounded;

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        assign pair_sum[g] = ACC_W'($signed(taps[g])) + ACC_W'($signed(taps[DEPTH-1-g]));
        assign prod[g]     = pair_sum[g] * ACC_W'(phase_coef(g));
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < PAIRS; i++) begin
            acc = acc + prod[i];
        end
        rounded = (acc + ACC_W'(1 << (SHIFT - 1))) >>> SHIFT;
        if (rounded > ACC_W'(MAXV))      result = W'(MAXV);
        else if (rounded < ACC_W'(MINV)) result = W'(MINV);
        else                             result = rounded[W-1:0];
    end
endmodule

// File: rtl/hbi_mixer.sv
module hbi_mixer #(
    parameter int W = 14
) (
    input  logic         sel_b,
    input  logic         negate_en,
    input  logic [W-1:0] a_val,
    input  logic [W-1:0] b_val,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_CODE = {1'b0, {(W-1){1'b1}}};

    always_comb begin
        if (!sel_b)                y = a_val;
        else if (!negate_en)       y = b_val;
        else if (b_val == MIN_CODE) y = MAX_CODE;
        else                       y = ~b_val + 1'b1;
    end
endmodule

// File: rtl/hb_interp2x.sv
module hb_interp2x
    import hbi_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int ACC_W    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                hp_mode,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data
);
    localparam int DEPTH  = PHASE_TAPS;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int CENTER = CENTER_IDX;

    typedef struct packed {
        logic                a_due;
        logic                b_due;
        logic [CNT_W-1:0]    fill;
        logic                vld;
        logic                is_b;
        logic [SAMPLE_W-1:0] data;
    } ctl_t;

    ctl_t st_d, st_q;

    logic                         accept;
    logic                         line_full;
    logic [DEPTH-1:0][SAMPLE_W-1:0] taps;
    logic [SAMPLE_W-1:0]          phase_a;
    logic [SAMPLE_W-1:0]          center_tap;
    logic [SAMPLE_W-1:0]          mix_y;
    logic                         emit_b_q;
    logic                         a_due_q;

    assign accept     = in_valid && !st_q.a_due;
    assign line_full  = (st_q.fill == CNT_W'(DEPTH));
    assign center_tap = taps[CENTER];

    hbi_tap_line #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_line (
        .clk      (clk),
        .rst      (rst),
        .shift_en (accept),
        .din      (in_data),
        .taps     (taps)
    );

    hbi_phase_mac #(.W(SAMPLE_W), .DEPTH(DEPTH), .ACC_W(ACC_W), .SHIFT(COEF_SHIFT)) u_mac (
        .taps   (taps),
        .result (phase_a)
    );

    hbi_mixer #(.W(SAMPLE_W)) u_mix (
        .sel_b     (st_q.b_due),
        .negate_en (hp_mode),
        .a_val     (phase_a),
        .b_val     (center_tap),
        .y         (mix_y)
    );

    always_comb begin
        st_d       = st_q;
        st_d.a_due = accept;
        st_d.b_due = st_q.a_due;
        if (accept && !line_full) st_d.fill = st_q.fill + 1'b1;
        st_d.vld  = (st_q.a_due || st_q.b_due) && line_full;
        st_d.is_b = st_q.b_due;
        if (st_q.a_due || st_q.b_due) st_d.data = mix_y;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign emit_b_q  = st_q.is_b;
    assign a_due_q   = st_q.a_due;
endmodule

// File: rtl/hb_interp2x_chk.sv
module hb_interp2x_chk #(
    parameter int W = 14
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         hp_mode,
    input logic         out_valid,
    input logic [W-1:0] out_data,
    input logic         emit_b,
    input logic         busy_a,
    input logic         line_full,
    input logic [W-1:0] center_tap
);
    localparam logic [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_CODE = {1'b0, {(W-1){1'b1}}};

    // R1: no output in the cycle after a reset cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R2: a phase-A output is always followed by phase B
    a_r2_b_follows_a: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !emit_b) |=> (out_valid && emit_b));

    // R2: phase B only right after phase A
    a_r2_b_after_a: assert property (@(posedge clk) disable iff (rst)
        (out_valid && emit_b) |-> $past(out_valid && !emit_b));

    // R4: low-pass phase B is the centre tap
    a_r4_center_copy: assert property (@(posedge clk) disable iff (rst)
        (out_valid && emit_b && !$past(hp_mode)) |-> (out_data == $past(center_tap)));

    // R7: high-pass phase B is the saturated negation of the centre tap
    a_r7_center_negated: assert property (@(posedge clk) disable iff (rst)
        (out_valid && emit_b && $past(hp_mode)) |->
        (($past(center_tap) == MIN_CODE) ? (out_data == MAX_CODE)
                                         : (out_data == W'(~$past(center_tap) + 1'b1))));

    // R8: valid outputs only once the line is full
    a_r8_fill_gate: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(line_full));

    // R9: a strobe during the busy cycle does not shift the line
    a_r9_busy_ignored: assert property (@(posedge clk) disable iff (rst)
        (in_valid && busy_a) |=> $stable(center_tap));
endmodule

bind hb_interp2x hb_interp2x_chk #(.W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .hp_mode    (hp_mode),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .emit_b     (emit_b_q),
    .busy_a     (a_due_q),
    .line_full  (line_full),
    .center_tap (center_tap)
);

// File: tb/tb_hb_interp2x.sv
`timescale 1ns/1ps
module tb_hb_interp2x;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [13:0]       in_data = '0;
    logic              hp_mode = 1'b0;
    logic              out_valid;
    logic signed [13:0] out_data;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    int  hist [22];
    int  n_acc    = 0;

    always #2.5 clk = ~clk;

    hb_interp2x dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .hp_mode(hp_mode), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int coef(input int i);
        int k;
        int tbl [11] = '{10, -31, 69, -138, 248, -419, 678, -1083, 1776, -3282, 10364};
        k = (i < 11) ? i : 21 - i;
        return tbl[k];
    endfunction

    function automatic int clip(input int v);
        if (v > 8191)  return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    function automatic int model_a();
        int s = 0;
        for (int i = 0; i < 22; i++) s += coef(i) * hist[i];
        return clip((s + 8192) >>> 14);
    endfunction

    task automatic model_push(input int x);
        for (int i = 21; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        if (n_acc < 22) n_acc++;
    endtask

    task automatic model_clear();
        for (int i = 0; i < 22; i++) hist[i] = 0;
        n_acc = 0;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One sample with idle gap; returns the observed phase outputs.
    task automatic send(input int x, input bit hp, input string req, output int a, output int b);
        int ea, eb;
        bit full;
        @(negedge clk);
        in_valid = 1'b1; in_data = 14'(x); hp_mode = hp;
        @(negedge clk);
        in_valid = 1'b0;
        model_push(x);
        ea = model_a();
        eb = hp ? clip(-hist[10]) : hist[10];
        full = (n_acc >= 22);
        @(negedge clk);
        a = out_data;
        check(out_valid == full, {req, "/R2/R8 A valid"}, out_valid, full);
        if (full) check(a == ea, {req, "/R3 phase A"}, a, ea);
        @(negedge clk);
        b = out_data;
        check(out_valid == full, {req, "/R2 B valid"}, out_valid, full);
        if (full) check(b == eb, {req, "/R4 phase B"}, b, eb);
        @(negedge clk);
        check(out_valid == 1'b0, {req, "/R2 idle"}, out_valid, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 during reset", out_valid, 0);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        check(out_valid == 1'b0, "R1 after reset", out_valid, 0);
    endtask

    task automatic t_fill_and_dc();
        int a, b;
        for (int i = 0; i < 30; i++) send(1000, 1'b0, "R8", a, b);
        check(a == 1000, "R5 dc phase A", a, 1000);
        check(b == 1000, "R5 dc phase B", b, 1000);
    endtask

    task automatic t_impulse();
        int a, b, peak_idx, peak_val, idx;
        for (int i = 0; i < 22; i++) send(0, 1'b0, "R3", a, b);
        peak_idx = -1; peak_val = -100000; idx = 0;
        for (int i = 0; i < 22; i++) begin
            send((i == 0) ? 8191 : 0, 1'b0, "R10", a, b);
            if (a > peak_val) begin peak_val = a; peak_idx = idx; end
            if (b > peak_val) begin peak_val = b; peak_idx = idx + 1; end
            idx += 2;
        end
        check(peak_idx == 21, "R10 peak position", peak_idx, 21);
        check(peak_val == 8191, "R10 peak value", peak_val, 8191);
    endtask

    task automatic t_saturation();
        int a, b;
        for (int i = 21; i >= 0; i--) send((coef(i) > 0) ? 8191 : -8192, 1'b0, "R6", a, b);
        check(a == 8191, "R6 positive clip", a, 8191);
        for (int i = 21; i >= 0; i--) send((coef(i) > 0) ? -8192 : 8191, 1'b0, "R6", a, b);
        check(a == -8192, "R6 negative clip", a, -8192);
    endtask

    task automatic t_highpass();
        int a, b;
        for (int i = 0; i < 30; i++) send(((i * 2749 + 311) % 16384) - 8192, 1'b1, "R7", a, b);
        for (int i = 0; i < 11; i++) send((i == 0) ? -8192 : 77, 1'b1, "R7", a, b);
        check(b == 8191, "R7 negate min code", b, 8191);
        send(77, 1'b1, "R7", a, b);
        check(b == -77, "R7 negate", b, -77);
    endtask

    task automatic t_ignore_busy();
        int ea, eb, a;
        @(negedge clk);
        in_valid = 1'b1; in_data = 14'(1234); hp_mode = 1'b0;
        @(negedge clk);
        in_data = 14'(-4000);
        model_push(1234);
        ea = model_a(); eb = hist[10];
        @(negedge clk);
        in_valid = 1'b0;
        a = out_data;
        check(a == ea, "R9 A with busy strobe", a, ea);
        @(negedge clk);
        check(out_data == 14'(eb), "R9 B with busy strobe", out_data, eb);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 busy strobe ignored", out_valid, 0);
    endtask

    task automatic t_every_other();
        int ea1, eb1, ea2, eb2;
        @(negedge clk);
        in_valid = 1'b1; in_data = 14'(500); hp_mode = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        model_push(500);
        ea1 = model_a(); eb1 = hist[10];
        @(negedge clk);
        check(out_valid && out_data == 14'(ea1), "R9 burst A1", out_data, ea1);
        in_valid = 1'b1; in_data = 14'(-2500);
        @(negedge clk);
        check(out_valid && out_data == 14'(eb1), "R9 burst B1", out_data, eb1);
        in_valid = 1'b0;
        model_push(-2500);
        ea2 = model_a(); eb2 = hist[10];
        @(negedge clk);
        check(out_valid && out_data == 14'(ea2), "R9 burst A2", out_data, ea2);
        @(negedge clk);
        check(out_valid && out_data == 14'(eb2), "R2 burst B2", out_data, eb2);
        @(negedge clk);
        check(out_valid == 1'b0, "R2 burst idle", out_valid, 0);
    endtask

    task automatic t_reset_refill();
        int a, b;
        do_reset();
        send(3000, 1'b0, "R1 refill", a, b);
        check(out_valid == 1'b0, "R1 no output after reset", out_valid, 0);
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        do_reset();
        t_fill_and_dc();
        t_impulse();
        t_saturation();
        t_highpass();
        t_ignore_busy();
        t_every_other();
        t_reset_refill();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule